// File: doc/BRIEF.md
# Hitless Reference Switch Phase Corrector

This block sits in front of a timing loop and keeps the phase seen by that loop continuous when the timing reference moves between a primary and a secondary input. Once per 125 µs frame it is given a signed phase sample. The sample measures the selected reference against the loop feedback. In normal operation the block forwards that sample minus an accumulated build-out delay.

When the reference changes, the block enters holdover. During holdover it freezes its output at the last good value. On the first frame it captures the phase of the new reference. On the second frame it loads a new delay so that the next output starts exactly where the old reference left off. Because each load is made relative to the already-corrected output, the delay is the sum of every phase step corrected so far.

A filtered active-low clear pin zeroes the delay. After that, the output follows the present reference directly. Low pulses shorter than a programmable number of clock cycles are ignored.

Top module: `hitless_ref_corrector`

## Requirements
- R1: A switch event is `sw_i` high in a cycle, or `ref_sel_i` differing from its value in the previous cycle. Any switch event sets `holdover_o` to 1 from the next clock cycle.
- R2: While `holdover_o` is 1, `phase_o` keeps the value it had when the switch event occurred.
- R3: Holdover lasts two frame strobes counted after the event. The first strobe captures `phase_i` and the second loads the delay. `holdover_o` returns to 0 in the cycle after the second strobe.
- R4: The delay loaded on leaving holdover equals the captured phase minus the held `phase_o`. This makes the first corrected output after holdover continue the pre-switch phase.
- R5: Delays add up across switches. After several switches, `phase_o` equals `phase_i` minus the sum of all corrected steps, using 16-bit two's complement wrap, in 1 ns units.
- R6: A switch event during holdover restarts the two-strobe count. The originally held output value is kept as the alignment target.
- R7: `clr_n_i` passes through a two-flop synchroniser. If it is held low for at least `CLR_MIN_CYC` synchronised cycles (default 30, which is 300 ns at 100 MHz), the delay becomes zero. A shorter low pulse leaves the delay unchanged.
- R8: After synchronous reset, `phase_o` is 0, `holdover_o` is 0 and the delay is 0. The level of `ref_sel_i` during reset does not produce a switch event.
- R9: Outside holdover, `phase_o` changes only in the cycle after a `frame_i` strobe. It then takes the value `phase_i - delay` sampled at that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | One-cycle strobe per 125 µs frame; `phase_i` is valid with it |
| ref_sel_i | input | 1 | Selected reference: 0 primary, 1 secondary |
| sw_i | input | 1 | One-cycle switch strobe |
| clr_n_i | input | 1 | Asynchronous active-low delay clear |
| phase_i | input | 16 | Signed phase sample, 1 ns units |
| phase_o | output | 16 | Signed corrected (virtual reference) phase |
| holdover_o | output | 1 | High for the whole holdover state |

## Verification
A table of frames is walked with no switch, with a switch strobe and with a select-level toggle. The two switch kinds have opposite step signs, which separates the event sources. It also distinguishes a delay that is replaced from one that accumulates. Directed sequences then issue a second switch in the middle of holdover. This tells a restarted count and a retained alignment target apart from a holdover that ends after two frames regardless. Clear pulses just under and well over the width threshold test that the filter rejects and accepts correctly. Changing `phase_i` without a strobe shows that output updates are gated by the strobe.

// File: rtl/hrc_pkg.sv
package hrc_pkg;
  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_CAP  = 2'd1,
    ST_LOAD = 2'd2
  } hrc_state_e;
endpackage

// File: rtl/hrc_clr_filter.sv
module hrc_clr_filter #(
  parameter int CLR_MIN_CYC = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_n_i,
  output logic clr_o
);
  localparam int CW = $clog2(CLR_MIN_CYC + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      cnt   <= '0;
      clr_o <= 1'b0;
    end else begin
      s1    <= clr_n_i;
      s2    <= s1;
      clr_o <= 1'b0;
      if (s2) begin
        cnt <= '0;
      end else if (cnt != CW'(CLR_MIN_CYC)) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(CLR_MIN_CYC - 1)) clr_o <= 1'b1;
      end
    end
  end

  AST_CLR_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    clr_o |=> !clr_o);  // R7
  AST_CLR_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    clr_o |-> !$past(s2));  // R7
endmodule

// File: rtl/hrc_switch_fsm.sv
module hrc_switch_fsm
  import hrc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_i,
  input  logic sel_i,
  input  logic sw_i,
  output logic hold_o,
  output logic evt_o,
  output logic cap_o,
  output logic ld_o,
  output logic upd_o
);
  hrc_state_e state, state_n;
  logic       sel_q;

  assign evt_o = sw_i | (sel_i != sel_q);
  assign cap_o = (state == ST_CAP)  & frame_i & ~evt_o;
  assign ld_o  = (state == ST_LOAD) & frame_i & ~evt_o;
  assign upd_o = (state == ST_NORM) & frame_i & ~evt_o;

  always_comb begin
    state_n = state;
    if (evt_o) begin
      state_n = ST_CAP;
    end else begin
      case (state)
        ST_CAP:  if (frame_i) state_n = ST_LOAD;
        ST_LOAD: if (frame_i) state_n = ST_NORM;
        default: state_n = ST_NORM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_NORM;
      sel_q  <= sel_i;
      hold_o <= 1'b0;
    end else begin
      state  <= state_n;
      sel_q  <= sel_i;
      hold_o <= (state_n != ST_NORM);
    end
  end

  AST_EVT_ENTERS_HOLD: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> hold_o);  // R1
  AST_LOAD_LEAVES_HOLD: assert property (@(posedge clk) disable iff (rst)
    ld_o |=> !hold_o);  // R3
  AST_CAP_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    cap_o |-> hold_o);  // R3
  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cap_o, ld_o, upd_o}));  // R6
endmodule

// File: rtl/hrc_delay_path.sv
module hrc_delay_path #(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               upd_i,
  input  logic               cap_i,
  input  logic               ld_i,
  input  logic               clr_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] delay_q;
  logic [PHASE_W-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      delay_q <= '0;
      cap_q   <= '0;
      phase_o <= '0;
    end else begin
      if (upd_i) phase_o <= phase_i - delay_q;
      if (cap_i) cap_q <= phase_i;
      if (clr_i)     delay_q <= '0;
      else if (ld_i) delay_q <= cap_q - phase_o;
    end
  end

  AST_CLR_ZEROES_DELAY: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (delay_q == '0));  // R7
  AST_LOAD_ALIGNS: assert property (@(posedge clk) disable iff (rst)
    (ld_i && !clr_i) |=> ((cap_q - delay_q) == phase_o));  // R4
  AST_OUT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(phase_o));  // R9
endmodule

// File: rtl/hitless_ref_corrector.sv
module hitless_ref_corrector #(
  parameter int PHASE_W     = 16,
  parameter int CLR_MIN_CYC = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_i,
  input  logic               ref_sel_i,
  input  logic               sw_i,
  input  logic               clr_n_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               holdover_o
);
  logic clr_p, evt, cap, ld, upd;

  hrc_clr_filter #(.CLR_MIN_CYC(CLR_MIN_CYC)) u_clr (
    .clk(clk), .rst(rst), .clr_n_i(clr_n_i), .clr_o(clr_p)
  );

  hrc_switch_fsm u_fsm (
    .clk(clk), .rst(rst), .frame_i(frame_i), .sel_i(ref_sel_i), .sw_i(sw_i),
    .hold_o(holdover_o), .evt_o(evt), .cap_o(cap), .ld_o(ld), .upd_o(upd)
  );

  hrc_delay_path #(.PHASE_W(PHASE_W)) u_dly (
    .clk(clk), .rst(rst), .phase_i(phase_i), .upd_i(upd), .cap_i(cap),
    .ld_i(ld), .clr_i(clr_p), .phase_o(phase_o)
  );

  AST_HOLD_FREEZES_OUT: assert property (@(posedge clk) disable iff (rst)
    holdover_o |-> $stable(phase_o));  // R2
  AST_EVT_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
    evt |=> $stable(phase_o));  // R2
endmodule

// File: tb/sim_hitless_ref_corrector.sv
module sim_hitless_ref_corrector;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N = 9;
  // kind: 0 no switch, 1 switch strobe, 2 select toggle
  localparam int KIND [0:N-1] = '{0, 0, 1, 0, 0, 0, 2, 0, 0};
  localparam int PH   [0:N-1] = '{100, 110, 500, 510, 520, 530, -200, -190, -180};
  localparam int OUTV [0:N-1] = '{100, 110, 110, 110, 130, 140, 140, 140, 160};
  localparam int HD   [0:N-1] = '{0, 0, 1, 0, 0, 0, 1, 0, 0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_i = 1'b0;
  logic        ref_sel_i = 1'b1;
  logic        sw_i = 1'b0;
  logic        clr_n_i = 1'b1;
  logic [15:0] phase_i = '0;
  logic [15:0] phase_o;
  logic        holdover_o;
  int          checks = 0;
  int          fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hitless_ref_corrector u0 (
    .clk(clk), .rst(rst), .frame_i(frame_i), .ref_sel_i(ref_sel_i), .sw_i(sw_i),
    .clr_n_i(clr_n_i), .phase_i(phase_i), .phase_o(phase_o), .holdover_o(holdover_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input int ph);
    @(negedge clk);
    phase_i = 16'(ph);
    frame_i = 1'b1;
    @(negedge clk);
    frame_i = 1'b0;
    #1;
  endtask

  task automatic strobe_sw();
    @(negedge clk);
    sw_i = 1'b1;
    @(negedge clk);
    sw_i = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R8 reset phase_o", $signed(phase_o), 0);
    chk("R8 reset holdover_o", int'(holdover_o), 0);

    for (int i = 0; i < N; i++) begin
      if (KIND[i] == 1) begin
        strobe_sw();
        chk("R1 holdover after strobe", int'(holdover_o), 1);
      end else if (KIND[i] == 2) begin
        @(negedge clk);
        ref_sel_i = ~ref_sel_i;
        @(negedge clk);
        #1;
        chk("R1 holdover after select toggle", int'(holdover_o), 1);
      end
      frame(PH[i]);
      chk("R4/R5 table phase_o", $signed(phase_o), OUTV[i]);
      chk("R3 table holdover_o", int'(holdover_o), HD[i]);
    end

    // R9: phase change without strobe has no effect
    @(negedge clk);
    phase_i = 16'(1234);
    repeat (3) @(negedge clk);
    #1;
    chk("R9 no strobe no update", $signed(phase_o), 160);

    // R6: switch inside holdover restarts, keeps held value 160
    strobe_sw();
    frame(300);
    chk("R2 held during holdover", $signed(phase_o), 160);
    strobe_sw();
    frame(700);
    chk("R6 still in holdover after restart", int'(holdover_o), 1);
    frame(800);
    chk("R6 holdover ends after second frame", int'(holdover_o), 0);
    chk("R2 held through load", $signed(phase_o), 160);
    frame(900);
    chk("R6 aligned to original held value", $signed(phase_o), 360);

    // R7 short clear pulse ignored (delay stays 540)
    @(negedge clk);
    clr_n_i = 1'b0;
    repeat (20) @(negedge clk);
    clr_n_i = 1'b1;
    repeat (6) @(negedge clk);
    frame(1000);
    chk("R7 short clear ignored", $signed(phase_o), 460);

    // R7 long clear zeroes delay
    @(negedge clk);
    clr_n_i = 1'b0;
    repeat (40) @(negedge clk);
    clr_n_i = 1'b1;
    repeat (6) @(negedge clk);
    frame(1000);
    chk("R7 long clear realigns", $signed(phase_o), 1000);
    chk("R7 no holdover from clear", int'(holdover_o), 0);

    summary();
    $finish;
  end
endmodule